// File: doc/BRIEF.md
# Floating-Point Result Sign Resolver and Class-Code Recorder

This block sits at the write-back end of a double-precision floating-point unit. In the cycle an operation completes, it settles the final sign of the result. The rules it applies are: the sign of an exactly cancelled subtraction depends on the rounding mode, a negate request inverts the sign of every result that is not a NaN, and a generated default quiet NaN is always positive. The settled sign is held in a register and drives bit 63 of the packed result. The other 63 bits are captured alongside it and passed on unchanged.

One cycle after completion, if the operation asked for it, the block derives a 5-bit class code from the registered sign and the packed exponent and fraction. It writes that code into bits 16:12 of a 32-bit status register. A single-precision result is held in double format, so for such a result a denormal is recognised by comparing the double-format biased exponent against a fixed threshold. The status register can also be loaded whole through a write port, and that load wins over a class update in the same cycle.

Top module: `frs_result_flags`

## Requirements
- R1: On a completing cycle with `is_sub_i`=1 and class zero (`cls_i`=2'b00), and no quiet-NaN generation, the pre-negate sign is `rmode_i[1] & rmode_i[0]`. Only mode 2'b11 (toward minus infinity) gives negative zero.
- R2: When `negate_i`=1 and the class is not NaN (`cls_i`!=2'b11), the sign is inverted after the R1 rule has been applied. Otherwise the sign is `raw_sign_i`.
- R3: When the class is NaN (`cls_i`=2'b11), `negate_i` has no effect and the sign stays `raw_sign_i`.
- R4: When `qnan_gen_i`=1, the result sign is 0 whatever the values of `raw_sign_i`, `negate_i`, `is_sub_i` and `rmode_i`.
- R5: On each clock edge where `done_i`=1, `result_o` becomes {resolved sign, `result_i[62:0]`}. It holds its value while `done_i`=0.
- R6: For a double result (`single_i`=0), take exponent = bits 62:52 and fraction = bits 51:0. Exponent 0x7FF with a nonzero fraction gives code 0x11 for either sign. Exponent 0x7FF with a zero fraction gives 0x09 (negative) or 0x05 (positive). Any other nonzero exponent gives 0x08 or 0x04. Exponent 0 with a nonzero fraction gives 0x18 or 0x14. All-zero gives 0x12 or 0x02.
- R7: For `single_i`=1, a result is normal only if the exponent exceeds 0x380. Below that, a nonzero exponent or a nonzero fraction gives the denormal codes 0x18 or 0x14. NaN, infinity and zero are coded as in R6.
- R8: When `upd_en_i`=1 on a completing cycle, the code is written into status bits 16:12 at the following clock edge. All other status bits keep their values.
- R9: When `upd_en_i`=0 (for example a plain move or negate), the status register does not change.
- R10: `stat_wr_i`=1 loads `stat_wdata_i` into all 32 status bits at the next edge. This load takes priority over a pending class update.
- R11: After synchronous reset, `status_o` and `result_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| done_i | input | 1 | Operation completes this cycle |
| raw_sign_i | input | 1 | Sign from the datapath before resolution |
| cls_i | input | 2 | Result class: 00 zero, 01 finite, 10 infinity, 11 NaN |
| result_i | input | 64 | Packed double-format result |
| single_i | input | 1 | Result is single precision held in double format |
| is_sub_i | input | 1 | Operation is an effective subtraction |
| negate_i | input | 1 | Negated form: invert final sign |
| qnan_gen_i | input | 1 | Default quiet NaN generated for an invalid operation |
| rmode_i | input | 2 | Rounding mode; 11 is toward minus infinity |
| upd_en_i | input | 1 | Record the class code for this result |
| stat_wr_i | input | 1 | Load the whole status register |
| stat_wdata_i | input | 32 | Value loaded into the status register |
| result_o | output | 64 | Packed result with resolved sign in bit 63 |
| status_o | output | 32 | Status register; class code in bits 16:12 |

## Verification
The assertions take for granted that `cls_i` agrees with the packed exponent and fraction, and that `qnan_gen_i` comes only with a NaN payload. The sign properties rely on this because they read the class from `cls_i`, while the status code is derived from the packed bits. The stimulus keeps to this assumption by pairing every packed pattern in the class sweep with the class it encodes. The sign sweep leaves `upd_en_i` low, so its arbitrary combinations of class and payload never reach the status register.

// File: rtl/frs_pkg.sv
package frs_pkg;
    localparam int DW          = 64;
    localparam int EXP_W       = 11;
    localparam int FRAC_W      = 52;
    localparam int STAT_W      = 32;
    localparam int CODE_W      = 5;
    localparam int CODE_LSB    = 12;
    localparam int CODE_MSB    = CODE_LSB + CODE_W - 1;
    localparam logic [EXP_W-1:0] EXP_MAX      = '1;
    localparam logic [EXP_W-1:0] SP_NORM_FLOOR = 11'h380;

    typedef enum logic [1:0] {
        FRS_ZERO   = 2'b00,
        FRS_FINITE = 2'b01,
        FRS_INF    = 2'b10,
        FRS_NAN    = 2'b11
    } frs_class_e;

    localparam logic [CODE_W-1:0] CODE_QNAN  = 5'h11;
    localparam logic [CODE_W-1:0] CODE_NINF  = 5'h09;
    localparam logic [CODE_W-1:0] CODE_PINF  = 5'h05;
    localparam logic [CODE_W-1:0] CODE_NNORM = 5'h08;
    localparam logic [CODE_W-1:0] CODE_PNORM = 5'h04;
    localparam logic [CODE_W-1:0] CODE_NDEN  = 5'h18;
    localparam logic [CODE_W-1:0] CODE_PDEN  = 5'h14;
    localparam logic [CODE_W-1:0] CODE_NZERO = 5'h12;
    localparam logic [CODE_W-1:0] CODE_PZERO = 5'h02;

    typedef struct packed {
        logic              sign;
        logic              single;
        logic              upd;
        logic [DW-2:0]     body;
    } frs_capture_t;

    function automatic logic [CODE_W-1:0] pick(input logic neg,
                                               input logic [CODE_W-1:0] n_code,
                                               input logic [CODE_W-1:0] p_code);
        return neg ? n_code : p_code;
    endfunction
endpackage

// File: rtl/frs_sign_resolve.sv
module frs_sign_resolve
    import frs_pkg::*;
(
    input  logic       raw_sign,
    input  frs_class_e cls,
    input  logic       is_sub,
    input  logic       negate,
    input  logic       qnan_gen,
    input  logic [1:0] rmode,
    output logic       sign
);
    logic zero_cancel;
    logic s_pre;

    assign zero_cancel = is_sub && (cls == FRS_ZERO);

    always_comb begin
        s_pre = zero_cancel ? (rmode[1] & rmode[0]) : raw_sign;
        if (qnan_gen)
            sign = 1'b0;
        else if (negate && (cls != FRS_NAN))
            sign = ~s_pre;
        else
            sign = s_pre;
    end
endmodule

// File: rtl/frs_capture.sv
module frs_capture
    import frs_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          done,
    input  logic          sign,
    input  logic          single,
    input  logic          upd_en,
    input  logic [DW-1:0] result,
    output frs_capture_t  cap
);
    always_ff @(posedge clk) begin
        if (rst) begin
            cap <= '0;
        end else begin
            cap.upd <= done & upd_en;
            if (done) begin
                cap.sign   <= sign;
                cap.single <= single;
                cap.body   <= result[DW-2:0];
            end
        end
    end
endmodule

// File: rtl/frs_class_encode.sv
module frs_class_encode
    import frs_pkg::*;
(
    input  logic              sign,
    input  logic              single,
    input  logic [DW-2:0]     body,
    output logic [CODE_W-1:0] code
);
    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic [EXP_W-1:0]  norm_floor;
    logic              frac_nz;
    logic              exp_nz;

    assign expo       = body[DW-2 -: EXP_W];
    assign frac       = body[FRAC_W-1:0];
    assign frac_nz    = |frac;
    assign exp_nz     = |expo;
    assign norm_floor = single ? SP_NORM_FLOOR : '0;

    always_comb begin
        if (expo == EXP_MAX)
            code = frac_nz ? CODE_QNAN : pick(sign, CODE_NINF, CODE_PINF);
        else if (expo > norm_floor)
            code = pick(sign, CODE_NNORM, CODE_PNORM);
        else if (exp_nz || frac_nz)
            code = pick(sign, CODE_NDEN, CODE_PDEN);
        else
            code = pick(sign, CODE_NZERO, CODE_PZERO);
    end
endmodule

// File: rtl/frs_status_reg.sv
module frs_status_reg
    import frs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr,
    input  logic [STAT_W-1:0] wdata,
    input  logic              upd,
    input  logic [CODE_W-1:0] code,
    output logic [STAT_W-1:0] status
);
    always_ff @(posedge clk) begin
        if (rst)
            status <= '0;
        else if (wr)
            status <= wdata;
        else if (upd)
            status[CODE_MSB:CODE_LSB] <= code;
    end
endmodule

// File: rtl/frs_result_flags.sv
module frs_result_flags
    import frs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              done_i,
    input  logic              raw_sign_i,
    input  logic [1:0]        cls_i,
    input  logic [DW-1:0]     result_i,
    input  logic              single_i,
    input  logic              is_sub_i,
    input  logic              negate_i,
    input  logic              qnan_gen_i,
    input  logic [1:0]        rmode_i,
    input  logic              upd_en_i,
    input  logic              stat_wr_i,
    input  logic [STAT_W-1:0] stat_wdata_i,
    output logic [DW-1:0]     result_o,
    output logic [STAT_W-1:0] status_o
);
    frs_class_e        cls;
    logic              sign_d;
    frs_capture_t      cap;
    logic              upd_q;
    logic [CODE_W-1:0] code;

    assign cls = frs_class_e'(cls_i);

    frs_sign_resolve u_sign (
        .raw_sign (raw_sign_i),
        .cls      (cls),
        .is_sub   (is_sub_i),
        .negate   (negate_i),
        .qnan_gen (qnan_gen_i),
        .rmode    (rmode_i),
        .sign     (sign_d)
    );

    frs_capture u_cap (
        .clk    (clk),
        .rst    (rst),
        .done   (done_i),
        .sign   (sign_d),
        .single (single_i),
        .upd_en (upd_en_i),
        .result (result_i),
        .cap    (cap)
    );

    assign upd_q    = cap.upd;
    assign result_o = {cap.sign, cap.body};

    frs_class_encode u_enc (
        .sign   (cap.sign),
        .single (cap.single),
        .body   (cap.body),
        .code   (code)
    );

    frs_status_reg u_stat (
        .clk    (clk),
        .rst    (rst),
        .wr     (stat_wr_i),
        .wdata  (stat_wdata_i),
        .upd    (upd_q),
        .code   (code),
        .status (status_o)
    );
endmodule

// File: rtl/frs_result_flags_chk.sv
module frs_result_flags_chk (
    input logic        clk,
    input logic        rst,
    input logic        done_i,
    input logic        raw_sign_i,
    input logic [1:0]  cls_i,
    input logic [63:0] result_i,
    input logic        is_sub_i,
    input logic        negate_i,
    input logic        qnan_gen_i,
    input logic [1:0]  rmode_i,
    input logic        stat_wr_i,
    input logic [31:0] stat_wdata_i,
    input logic        upd_q,
    input logic [63:0] result_o,
    input logic [31:0] status_o
);
    // R1
    zero_cancel_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (done_i && !qnan_gen_i && is_sub_i && cls_i == 2'b00 && !negate_i)
        |=> (result_o[63] == (&$past(rmode_i))));

    // R2
    negate_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (done_i && !qnan_gen_i && !is_sub_i && negate_i && cls_i != 2'b11)
        |=> (result_o[63] == !$past(raw_sign_i)));

    // R3
    nan_keeps_sign_chk: assert property (@(posedge clk) disable iff (rst)
        (done_i && !qnan_gen_i && cls_i == 2'b11)
        |=> (result_o[63] == $past(raw_sign_i)));

    // R4
    qnan_positive_chk: assert property (@(posedge clk) disable iff (rst)
        (done_i && qnan_gen_i) |=> !result_o[63]);

    // R5
    body_pass_chk: assert property (@(posedge clk) disable iff (rst)
        done_i |=> (result_o[62:0] == $past(result_i[62:0])));

    // R5
    hold_result_chk: assert property (@(posedge clk) disable iff (rst)
        !done_i |=> $stable(result_o));

    // R8
    field_only_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_q && !stat_wr_i)
        |=> (status_o[31:17] == $past(status_o[31:17]) &&
             status_o[11:0] == $past(status_o[11:0])));

    // R9
    no_update_chk: assert property (@(posedge clk) disable iff (rst)
        (!upd_q && !stat_wr_i) |=> $stable(status_o));

    // R10
    load_wins_chk: assert property (@(posedge clk) disable iff (rst)
        stat_wr_i |=> (status_o == $past(stat_wdata_i)));
endmodule

bind frs_result_flags frs_result_flags_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .done_i       (done_i),
    .raw_sign_i   (raw_sign_i),
    .cls_i        (cls_i),
    .result_i     (result_i),
    .is_sub_i     (is_sub_i),
    .negate_i     (negate_i),
    .qnan_gen_i   (qnan_gen_i),
    .rmode_i      (rmode_i),
    .stat_wr_i    (stat_wr_i),
    .stat_wdata_i (stat_wdata_i),
    .upd_q        (upd_q),
    .result_o     (result_o),
    .status_o     (status_o)
);

// File: tb/frs_result_flags_tb.sv
module frs_result_flags_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        done_i = 1'b0;
    logic        raw_sign_i = 1'b0;
    logic [1:0]  cls_i = 2'b00;
    logic [63:0] result_i = '0;
    logic        single_i = 1'b0;
    logic        is_sub_i = 1'b0;
    logic        negate_i = 1'b0;
    logic        qnan_gen_i = 1'b0;
    logic [1:0]  rmode_i = 2'b00;
    logic        upd_en_i = 1'b0;
    logic        stat_wr_i = 1'b0;
    logic [31:0] stat_wdata_i = '0;
    logic [63:0] result_o;
    logic [31:0] status_o;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    frs_result_flags dut_i (
        .clk(clk), .rst(rst), .done_i(done_i), .raw_sign_i(raw_sign_i),
        .cls_i(cls_i), .result_i(result_i), .single_i(single_i),
        .is_sub_i(is_sub_i), .negate_i(negate_i), .qnan_gen_i(qnan_gen_i),
        .rmode_i(rmode_i), .upd_en_i(upd_en_i), .stat_wr_i(stat_wr_i),
        .stat_wdata_i(stat_wdata_i), .result_o(result_o), .status_o(status_o)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic exp_sign(input logic raw, input logic [1:0] c, input logic sub,
                                      input logic neg, input logic qn, input logic [1:0] rm);
        logic s;
        if (qn) return 1'b0;
        s = raw;
        if (sub && c == 2'b00) s = (rm == 2'b11);
        if (neg && c != 2'b11) s = !s;
        return s;
    endfunction

    function automatic logic [4:0] exp_code(input logic s, input logic sp, input logic [63:0] v);
        int e;
        logic fnz;
        e = int'(v[62:52]);
        fnz = (v[51:0] != 0);
        if (e == 2047) return fnz ? 5'h11 : (s ? 5'h09 : 5'h05);
        if (e > (sp ? 896 : 0)) return s ? 5'h08 : 5'h04;
        if (e != 0 || fnz) return s ? 5'h18 : 5'h14;
        return s ? 5'h12 : 5'h02;
    endfunction

    task automatic load_status(input logic [31:0] v);
        @(negedge clk);
        stat_wr_i = 1'b1;
        stat_wdata_i = v;
        @(negedge clk);
        stat_wr_i = 1'b0;
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=hung expected=finished");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R11
        check("R11 status", {32'h0, status_o}, 64'h0);
        check("R11 result", result_o, 64'h0);

        // R10: whole-register load
        load_status(32'hA5C3_5A3C);
        check("R10 load", {32'h0, status_o}, {32'h0, 32'hA5C3_5A3C});

        // R1 R2 R3 R4 R5 R9: sweep every sign-control combination, no class update
        for (int i = 0; i < 256; i++) begin
            logic [7:0] b;
            logic [63:0] pay;
            logic es;
            b = 8'(i);
            pay = {1'b0, 7'(i), 56'h1234_5678_9ABC_DE} ^ {b[0], 63'h0};
            es = exp_sign(b[0], b[2:1], b[3], b[4], b[5], b[7:6]);
            @(negedge clk);
            done_i = 1'b1;
            raw_sign_i = b[0]; cls_i = b[2:1]; is_sub_i = b[3];
            negate_i = b[4]; qnan_gen_i = b[5]; rmode_i = b[7:6];
            result_i = pay;
            @(negedge clk);
            done_i = 1'b0;
            if (b[5]) check("R4 qnan sign", {63'h0, result_o[63]}, {63'h0, es});
            else if (b[2:1] == 2'b11) check("R3 nan sign", {63'h0, result_o[63]}, {63'h0, es});
            else if (b[3] && b[2:1] == 2'b00) check("R1 zero sign", {63'h0, result_o[63]}, {63'h0, es});
            else check("R2 negate sign", {63'h0, result_o[63]}, {63'h0, es});
            check("R5 body", {1'b0, result_o[62:0]}, {1'b0, pay[62:0]});
            result_i = ~pay;
            @(negedge clk);
            check("R5 hold", result_o, {es, pay[62:0]});
        end
        check("R9 status untouched", {32'h0, status_o}, {32'h0, 32'hA5C3_5A3C});
        qnan_gen_i = 1'b0; is_sub_i = 1'b0; negate_i = 1'b0;

        // R6 R7 R8: class-code sweep with all other status bits set
        load_status(32'hFFFF_FFFF);
        for (int ei = 0; ei < 9; ei++) begin
            for (int k = 0; k < 8; k++) begin
                logic [10:0] ex;
                logic [63:0] v;
                logic [31:0] want;
                logic s, sp, fnz;
                case (ei)
                    0: ex = 11'h000; 1: ex = 11'h001; 2: ex = 11'h37F;
                    3: ex = 11'h380; 4: ex = 11'h381; 5: ex = 11'h3FF;
                    6: ex = 11'h7FE; 7: ex = 11'h7FF; default: ex = 11'h400;
                endcase
                s = k[0]; sp = k[1]; fnz = k[2];
                v = {s, ex, fnz ? 52'h8_0000_0000_0001 : 52'h0};
                want = (32'hFFFF_FFFF & ~32'h0001_F000) | ({27'h0, exp_code(s, sp, v)} << 12);
                @(negedge clk);
                done_i = 1'b1; upd_en_i = 1'b1;
                raw_sign_i = s; single_i = sp; result_i = v;
                cls_i = (ex == 11'h7FF) ? (fnz ? 2'b11 : 2'b10) : ((ex == 0 && !fnz) ? 2'b00 : 2'b01);
                @(negedge clk);
                done_i = 1'b0; upd_en_i = 1'b0;
                @(negedge clk);
                check(sp ? "R7 sp class code" : "R6 dp class code", {32'h0, status_o}, {32'h0, want});
                load_status(32'hFFFF_FFFF);
            end
        end
        check("R8 other bits kept", {32'h0, status_o}, {32'h0, 32'hFFFF_FFFF});

        // R10: load in the same cycle as a pending class update wins
        @(negedge clk);
        done_i = 1'b1; upd_en_i = 1'b1; raw_sign_i = 1'b0; cls_i = 2'b01;
        single_i = 1'b0; result_i = 64'h3FF0_0000_0000_0000;
        @(negedge clk);
        done_i = 1'b0; upd_en_i = 1'b0;
        stat_wr_i = 1'b1; stat_wdata_i = 32'h1234_5678;
        @(negedge clk);
        stat_wr_i = 1'b0;
        check("R10 load priority", {32'h0, status_o}, {32'h0, 32'h1234_5678});

        // R9: move-like completion with cleared status leaves it zero
        load_status(32'h0);
        @(negedge clk);
        done_i = 1'b1; negate_i = 1'b1; raw_sign_i = 1'b1; result_i = 64'hBFF0_0000_0000_0000;
        @(negedge clk);
        done_i = 1'b0; negate_i = 1'b0;
        @(negedge clk);
        check("R9 move keeps zero", {32'h0, status_o}, 64'h0);
        check("R2 move negated", result_o, 64'h3FF0_0000_0000_0000);

        finish_run();
    end
endmodule